// File: doc/BRIEF.md
# Serial Setting Word Transmitter

This block is the host-side driver for a three-wire programming link made of a serial clock, a serial data line and a latch strobe. A word handed over through a valid/ready handshake is shifted out most significant bit first, one bit per serial clock period. Once the last bit has been clocked, a separate strobe pulse tells the receiver to copy its shift register into its holding latch.

Every interval on the link is a parameter given in nanoseconds. Each one is turned into a count of system clock cycles by rounding up against the system clock frequency parameter. The strobe stays low between transfers, so the receiver keeps its programmed setting. A new word can be offered as soon as the strobe of the previous one has fallen, which lets words follow back-to-back.

Top module: `setting_word_tx`

## Requirements
- R1: After reset, serClk, serStrobe, busy and done are low and inReady is high.
- R2: A word is taken in a cycle where inValid and inReady are both high. From the next cycle, busy is high and inReady is low until the strobe of that word has fallen.
- R3: Each word produces exactly WORD_W rising edges of serClk before its strobe rises. The value on serData at the k-th rising edge (k counted from 0) is bit WORD_W-1-k of the word, so the most significant bit goes first.
- R4: serData changes only while serClk is low. At each rising edge, serData has been stable for at least the low-phase time (default 80 cycles, at least 125 ns).
- R5: serClk stays high for exactly the high-phase count (default 80 cycles). From one rising edge to the next there are at least 160 cycles at 200 MHz, which keeps the rate at or below 1.25 MHz.
- R6: serStrobe rises while serClk is low, at least the clock-to-strobe count (default 52 cycles, 260 ns) after the rising edge that carried the last bit.
- R7: serStrobe stays high for exactly the strobe-width count (default 40 cycles, 200 ns) and then returns low.
- R8: done is a one-cycle pulse in the first cycle in which serStrobe is low again. inReady is high in that same cycle.
- R9: While no transfer runs, serClk and serStrobe stay low. A request with inValid high while busy is ignored and does not alter the word being sent.
- R10: A word offered while the previous transfer runs is taken in the done cycle. Its first rising serClk edge comes only after serStrobe has fallen, and serStrobe is never high together with serClk.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | A word is offered |
| inWord | input | WORD_W | Word to send |
| inReady | output | 1 | Block can take a word |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when the strobe has fallen |
| serClk | output | 1 | Serial clock, idles low |
| serData | output | 1 | Serial data, changes at falling serClk |
| serStrobe | output | 1 | Latch strobe, idles low |

## Verification
The assertions assume that inValid and inWord follow the handshake: a word is held until inReady is seen. The timing limits they check are the receiver's minimum figures, converted with the same 200 MHz clock the bench uses. The bench drives its inputs only at falling system clock edges. It keeps inValid high while the block is busy only to show that such a request is ignored, and it offers words both after long idle gaps and back-to-back, so that every check meets both situations.

// File: rtl/sswt_pkg.sv
package sswt_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOW,
    S_HIGH,
    S_TAIL,
    S_STRB
  } txState_t;

  typedef struct packed {
    logic load;
    logic shift;
    logic clkRise;
    logic clkFall;
    logic strbRise;
    logic strbFall;
  } ctrlStrobes_t;

  // round a time in ns up to whole system clock cycles, never below one
  function automatic int nsToCycles(longint clkHz, longint ns);
    longint c;
    c = (ns * clkHz + 64'd999_999_999) / 64'd1_000_000_000;
    return (c < 1) ? 1 : int'(c);
  endfunction

endpackage

// File: rtl/sswt_ctrl.sv
module sswt_ctrl
  import sswt_pkg::*;
#(
  parameter int WORD_W   = 8,
  parameter int LOW_CYC  = 80,
  parameter int HIGH_CYC = 80,
  parameter int TAIL_CYC = 1,
  parameter int STRB_CYC = 40
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         inValid,
  output logic         inReady,
  output logic         busy,
  output ctrlStrobes_t strobes
);
  localparam int MAX_AB  = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
  localparam int MAX_CD  = (TAIL_CYC > STRB_CYC) ? TAIL_CYC : STRB_CYC;
  localparam int MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int BIT_W   = (WORD_W > 2) ? $clog2(WORD_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  txState_t         state, nextState;
  logic [CNT_W-1:0] cnt, nextCnt;
  logic [BIT_W-1:0] bitIdx, nextBitIdx;
  logic             cntZero;

  assign cntZero = (cnt == '0);
  assign inReady = (state == S_IDLE);
  assign busy    = (state != S_IDLE);

  always_comb begin
    strobes    = '0;
    nextState  = state;
    nextCnt    = cntZero ? cnt : cnt - 1'b1;
    nextBitIdx = bitIdx;
    unique case (state)
      S_IDLE: begin
        if (inValid) begin
          strobes.load = 1'b1;
          nextState    = S_LOW;
          nextCnt      = CNT_W'(LOW_CYC - 1);
          nextBitIdx   = '0;
        end
      end
      S_LOW: begin
        if (cntZero) begin
          strobes.clkRise = 1'b1;
          nextState       = S_HIGH;
          nextCnt         = CNT_W'(HIGH_CYC - 1);
        end
      end
      S_HIGH: begin
        if (cntZero) begin
          strobes.clkFall = 1'b1;
          if (bitIdx == LAST_BIT) begin
            nextState = S_TAIL;
            nextCnt   = CNT_W'(TAIL_CYC - 1);
          end else begin
            strobes.shift = 1'b1;
            nextBitIdx    = bitIdx + 1'b1;
            nextState     = S_LOW;
            nextCnt       = CNT_W'(LOW_CYC - 1);
          end
        end
      end
      S_TAIL: begin
        if (cntZero) begin
          strobes.strbRise = 1'b1;
          nextState        = S_STRB;
          nextCnt          = CNT_W'(STRB_CYC - 1);
        end
      end
      S_STRB: begin
        if (cntZero) begin
          strobes.strbFall = 1'b1;
          nextState        = S_IDLE;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      cnt    <= '0;
      bitIdx <= '0;
    end else begin
      state  <= nextState;
      cnt    <= nextCnt;
      bitIdx <= nextBitIdx;
    end
  end

endmodule

// File: rtl/sswt_datapath.sv
module sswt_datapath
  import sswt_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [WORD_W-1:0] inWord,
  output logic              serClk,
  output logic              serData,
  output logic              serStrobe,
  output logic              done
);
  logic [WORD_W-1:0] shiftReg;

  assign serData = shiftReg[WORD_W-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg  <= '0;
      serClk    <= 1'b0;
      serStrobe <= 1'b0;
      done      <= 1'b0;
    end else begin
      if (strobes.load)
        shiftReg <= inWord;
      else if (strobes.shift)
        shiftReg <= {shiftReg[WORD_W-2:0], 1'b0};

      if (strobes.clkRise)
        serClk <= 1'b1;
      else if (strobes.clkFall)
        serClk <= 1'b0;

      if (strobes.strbRise)
        serStrobe <= 1'b1;
      else if (strobes.strbFall)
        serStrobe <= 1'b0;

      done <= strobes.strbFall;
    end
  end

endmodule

// File: rtl/setting_word_tx.sv
module setting_word_tx
  import sswt_pkg::*;
#(
  parameter int CLK_HZ         = 200_000_000,
  parameter int WORD_W         = 8,
  parameter int CLK_LOW_NS     = 400,
  parameter int CLK_HIGH_NS    = 400,
  parameter int CLK_TO_STRB_NS = 260,
  parameter int STRB_WIDTH_NS  = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [WORD_W-1:0] inWord,
  output logic              inReady,
  output logic              busy,
  output logic              done,
  output logic              serClk,
  output logic              serData,
  output logic              serStrobe
);
  localparam int LOW_CYC  = nsToCycles(CLK_HZ, CLK_LOW_NS);
  localparam int HIGH_CYC = nsToCycles(CLK_HZ, CLK_HIGH_NS);
  localparam int CS_CYC   = nsToCycles(CLK_HZ, CLK_TO_STRB_NS);
  localparam int STRB_CYC = nsToCycles(CLK_HZ, STRB_WIDTH_NS);
  // the high phase already counts toward the clock-to-strobe gap
  localparam int TAIL_CYC = (CS_CYC > HIGH_CYC) ? CS_CYC - HIGH_CYC : 1;

  ctrlStrobes_t strobes;

  sswt_ctrl #(
    .WORD_W  (WORD_W),
    .LOW_CYC (LOW_CYC),
    .HIGH_CYC(HIGH_CYC),
    .TAIL_CYC(TAIL_CYC),
    .STRB_CYC(STRB_CYC)
  ) ctrlInst (
    .clk    (clk),
    .rstN   (rstN),
    .inValid(inValid),
    .inReady(inReady),
    .busy   (busy),
    .strobes(strobes)
  );

  sswt_datapath #(
    .WORD_W(WORD_W)
  ) dpInst (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .inWord   (inWord),
    .serClk   (serClk),
    .serData  (serData),
    .serStrobe(serStrobe),
    .done     (done)
  );

endmodule

// File: rtl/setting_word_tx_chk.sv
module setting_word_tx_chk
  import sswt_pkg::*;
#(
  parameter int CLK_HZ = 200_000_000
) (
  input logic clk,
  input logic rstN,
  input logic inValid,
  input logic inReady,
  input logic busy,
  input logic done,
  input logic serClk,
  input logic serData,
  input logic serStrobe
);
  // receiver minima, independent of the transmitter's own settings
  localparam int SETUP_MIN  = nsToCycles(CLK_HZ, 125);
  localparam int HIGH_MIN   = nsToCycles(CLK_HZ, 200);
  localparam int PERIOD_MIN = nsToCycles(CLK_HZ, 800);
  localparam int CS_MIN     = nsToCycles(CLK_HZ, 260);
  localparam int SW_MIN     = nsToCycles(CLK_HZ, 200);

  logic        prevClk, prevStrb, prevData;
  logic [15:0] dataAge, riseAge, strbAge;
  logic        clkRise, clkFall, strbRise, strbFall;

  assign clkRise  = serClk && !prevClk;
  assign clkFall  = !serClk && prevClk;
  assign strbRise = serStrobe && !prevStrb;
  assign strbFall = !serStrobe && prevStrb;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevClk  <= 1'b0;
      prevStrb <= 1'b0;
      prevData <= 1'b0;
      dataAge  <= 16'hFFFF;
      riseAge  <= 16'hFFFF;
      strbAge  <= 16'hFFFF;
    end else begin
      prevClk  <= serClk;
      prevStrb <= serStrobe;
      prevData <= serData;
      dataAge  <= (serData != prevData) ? 16'd1 :
                  (dataAge == 16'hFFFF) ? dataAge : dataAge + 16'd1;
      riseAge  <= clkRise ? 16'd1 :
                  (riseAge == 16'hFFFF) ? riseAge : riseAge + 16'd1;
      strbAge  <= strbRise ? 16'd1 :
                  (strbAge == 16'hFFFF) ? strbAge : strbAge + 16'd1;
    end
  end

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> (busy && !inReady));
  // R4
  data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (serClk && prevClk) |-> (serData == prevData));
  // R4
  data_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    clkRise |-> (dataAge >= 16'(SETUP_MIN)));
  // R5
  clk_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    clkFall |-> (riseAge >= 16'(HIGH_MIN)));
  // R5
  clk_rate_chk: assert property (@(posedge clk) disable iff (!rstN)
    clkRise |-> (riseAge >= 16'(PERIOD_MIN)));
  // R6
  strb_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    strbRise |-> (!serClk && riseAge >= 16'(CS_MIN)));
  // R7
  strb_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    strbFall |-> (strbAge >= 16'(SW_MIN)));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (strbFall && inReady));
  // R9
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!serClk && !serStrobe));
  // R10
  strb_clk_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    serStrobe |-> !serClk);

endmodule

bind setting_word_tx setting_word_tx_chk #(.CLK_HZ(CLK_HZ)) chkInst (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .inReady  (inReady),
  .busy     (busy),
  .done     (done),
  .serClk   (serClk),
  .serData  (serData),
  .serStrobe(serStrobe)
);

// File: tb/setting_word_tx_test.sv
`timescale 1ns/1ps
module setting_word_tx_test;
  // expected counts at 200 MHz (5 ns per cycle)
  localparam int LOW_EXP  = 400 / 5;
  localparam int HIGH_EXP = 400 / 5;
  localparam int CS_EXP   = 260 / 5;
  localparam int SW_EXP   = 200 / 5;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       inValid = 1'b0;
  logic [7:0] inWord = '0;
  logic       inReady, busy, done, serClk, serData, serStrobe;

  int tests = 0;
  int fails = 0;
  bit summaryDone = 1'b0;
  logic [7:0] expQ[$];

  always #2.5 clk = ~clk;

  setting_word_tx uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inWord(inWord),
    .inReady(inReady), .busy(busy), .done(done),
    .serClk(serClk), .serData(serData), .serStrobe(serStrobe)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // driver: offers a word and records it on the scoreboard
  task automatic sendWord(input logic [7:0] w, input bit expectDoneCycle);
    @(negedge clk);
    while (!inReady) @(negedge clk);
    // R10: a waiting word is taken in the done cycle
    if (expectDoneCycle) check(done == 1'b1, "R10 accept in done cycle", done, 1);
    inValid = 1'b1;
    inWord  = w;
    expQ.push_back(w);
    @(negedge clk);
    // R2: busy and not ready after acceptance
    check(busy && !inReady, "R2 busy after accept", {busy, inReady}, 2);
    inValid = 1'b0;
  endtask

  // monitor: rebuilds each word from the serial lines
  initial begin : monitor
    int cyc = 0;
    int lastRise = 0, lastDataChg = 0, strbStart = 0, bitsSeen = 0;
    logic pClk = 1'b0, pStrb = 1'b0, pData = 1'b0;
    logic [7:0] got = '0;
    logic [7:0] exp;
    forever begin
      @(negedge clk);
      cyc++;
      if (rstN) begin
        if (serData !== pData) begin
          // R4: no data change while the serial clock is high
          if (pClk && serClk) check(1'b0, "R4 data moved while clock high", serData, pData);
          lastDataChg = cyc;
        end
        if (serClk && !pClk) begin
          // R4: setup time before the rising edge
          check(cyc - lastDataChg >= LOW_EXP, "R4 setup", cyc - lastDataChg, LOW_EXP);
          // R10: no rising edge while strobe is high
          check(!serStrobe, "R10 clock with strobe", serStrobe, 0);
          got = {got[6:0], serData};
          bitsSeen++;
          lastRise = cyc;
        end
        if (!serClk && pClk)
          // R5: exact high phase
          check(cyc - lastRise == HIGH_EXP, "R5 high phase", cyc - lastRise, HIGH_EXP);
        if (serStrobe && !pStrb) begin
          // R3: bit count and MSB-first content
          check(bitsSeen == 8, "R3 bit count", bitsSeen, 8);
          if (expQ.size() == 0) begin
            check(1'b0, "R3 unexpected word", got, 0);
          end else begin
            exp = expQ.pop_front();
            check(got == exp, "R3 word content", got, exp);
          end
          // R6: clock low and gap from the last rising edge
          check(!serClk && (cyc - lastRise >= CS_EXP), "R6 clock to strobe",
                cyc - lastRise, CS_EXP);
          bitsSeen = 0;
          strbStart = cyc;
        end
        if (!serStrobe && pStrb) begin
          // R7: strobe width
          check(cyc - strbStart == SW_EXP, "R7 strobe width", cyc - strbStart, SW_EXP);
          // R8: done pulse and ready in the same cycle
          check(done && inReady, "R8 done with strobe fall", {done, inReady}, 3);
        end else if (done) begin
          check(1'b0, "R8 stray done", done, 0);
        end
      end
      pClk = serClk;
      pStrb = serStrobe;
      pData = serData;
    end
  end

  initial begin : watchdog
    repeat (150_000) @(posedge clk);
    check(1'b0, "watchdog expired", 1, 0);
    finishRun();
  end

  initial begin : stimulus
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(!serClk && !serStrobe && !busy && !done && inReady, "R1 reset state",
          {serClk, serStrobe, busy, done, inReady}, 1);

    sendWord(8'hA5, 1'b0);
    // R9: requests while busy are ignored
    inValid = 1'b1;
    inWord  = 8'h5A;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (i % 100 == 0) check(busy && !inReady, "R9 ignored while busy", busy, 1);
    end
    inValid = 1'b0;
    while (busy) @(negedge clk);
    repeat (50) @(negedge clk);
    // R9: lines idle low between transfers
    check(!serClk && !serStrobe, "R9 idle lines", {serClk, serStrobe}, 0);

    sendWord(8'h00, 1'b0);
    sendWord(8'hFF, 1'b1);
    sendWord(8'h80, 1'b1);
    sendWord(8'h01, 1'b1);
    while (busy) @(negedge clk);
    repeat (20) @(negedge clk);
    sendWord(8'h3C, 1'b0);
    sendWord(8'hC3, 1'b1);
    while (busy || expQ.size() != 0) @(negedge clk);
    repeat (10) @(negedge clk);
    check(expQ.size() == 0, "R3 scoreboard drained", expQ.size(), 0);
    finishRun();
  end

endmodule